// File: doc/BRIEF.md
# SDRAM Bank Command State Tracker

This block observes the command pins of a two-bank synchronous DRAM interface on every rising clock edge and keeps, for each bank, a record of what that bank is doing. The record is one of these conditions: idle, row open, burst read, burst write, burst read or write followed by an automatic close, or the close that comes after such a burst. Each observed command is decoded, checked against the current condition of the bank it addresses, and then either moves that bank on or is flagged as not permitted.

Bursts end by themselves after a parameterised number of cycles. A burst that was issued with the auto-close bit set runs a fixed number of close cycles and then returns the bank to idle. Refresh and mode-register commands are device-wide and are accepted only when every bank is idle. A monitor or protocol checker next to a memory controller uses the block to catch command sequences that break the bank rules, through the one-cycle `illegal_o` pulse and the per-bank condition outputs.

Top module: `sdt_bank_tracker`

## Requirements
- R1: After reset, every bank reports condition code 0 (idle), `open_row_o` is zero and `illegal_o` is low. All outputs are registered and show the result of a command in the cycle after the clock edge that samples it.
- R2: The command is taken from {ras_n,cas_n,we_n} while cs_n is low: 111 no-op, 110 burst stop, 011 open row, 010 close, 001 refresh, 000 mode-register write, 101 read, 100 write. A cycle with cs_n high is a no-op. It never raises `illegal_o`, and a running burst keeps counting through it.
- R3: An open-row command to an idle bank moves it to code 1 (row open) and latches `row_addr` into that bank's field of `open_row_o`.
- R4: A read or write to a bank in code 1, 2 or 3 starts a burst. The bank enters code 2 (read) or 3 (write) when `ap_bit` is 0, and code 4 (read then close) or 5 (write then close) when it is 1. The bank holds that code for BURST_LEN cycles. A burst in code 2 or 3 then returns the bank to code 1.
- R5: When a code 4 or 5 burst ends, the bank shows code 6 (closing) for PRE_CYCLES cycles and then code 0.
- R6: In code 2, a burst stop returns the bank to code 1 at once. A new read or write in code 2 or 3 cuts the running burst and starts a full new one.
- R7: A close command moves a bank in code 1, 2 or 3 to code 0. In code 0 it is accepted and changes nothing.
- R8: These commands are flagged: open row outside code 0; read, write or burst stop in code 0; burst stop in code 1 or 3; any command except no-op in codes 4, 5 and 6. A flagged command raises `illegal_o` for exactly the following cycle and is otherwise treated as a no-op, so no bank changes condition or row because of it.
- R9: Refresh and mode-register commands ignore `bank_sel`. They are accepted only when every bank shows code 0, are flagged otherwise, and never change any bank.
- R10: `bank_sel` chooses the bank that a per-bank command addresses. The other bank changes only through its own burst or close counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| bank_sel | input | BA_W (1) | Bank addressed by the command |
| ap_bit | input | 1 | Auto-close request on read/write |
| row_addr | input | ROW_W (12) | Row address captured on open-row |
| bank_state_o | output | 3*BANKS (6) | Condition code per bank, bank b at bits [3b+2:3b] |
| open_row_o | output | ROW_W*BANKS (24) | Latched row per bank, bank b at bits [ROW_W*b +: ROW_W] |
| illegal_o | output | 1 | One-cycle flag for a command that was not permitted |

## Verification
The hardest situations to reach from the ports are commands that land on a bank while its burst counter sits at its last count, or while the other bank is closing on its own. A command arriving then has to be judged against the condition the bank is leaving, not the one it is entering. Purely random pins rarely produce long legal sequences, so the random phase is weighted towards commands that are legal in the bank's current condition. A reference model in the bench shadows both banks, which lets random bursts, interruptions and refreshes collide at arbitrary counter values. Directed sequences first cover each cut-off, auto-close and device-wide rejection on its own.

// File: rtl/sdt_pkg.sv
// Package: shared types for the SDRAM bank command state tracker.
// Assumes the command code equals {ras_n,cas_n,we_n} sampled while cs_n is low.
package sdt_pkg;

    // Per-bank condition codes; the values are visible on the ports.
    typedef enum logic [2:0] {
        BK_IDLE   = 3'd0,
        BK_OPEN   = 3'd1,
        BK_RD     = 3'd2,
        BK_WR     = 3'd3,
        BK_RD_AP  = 3'd4,
        BK_WR_AP  = 3'd5,
        BK_CLOSE  = 3'd6,
        BK_UNUSED = 3'd7
    } bank_st_e;

    // Decoded commands; the value is the raw {ras_n,cas_n,we_n} pattern.
    typedef enum logic [2:0] {
        C_MRS = 3'b000,
        C_REF = 3'b001,
        C_PRE = 3'b010,
        C_ACT = 3'b011,
        C_WR  = 3'b100,
        C_RD  = 3'b101,
        C_BST = 3'b110,
        C_NOP = 3'b111
    } cmd_e;

    // True for conditions in which a burst counter is running.
    function automatic logic in_burst(bank_st_e s);
        return (s == BK_RD) || (s == BK_WR) || (s == BK_RD_AP) || (s == BK_WR_AP);
    endfunction

endpackage

// File: rtl/sdt_cmd_decode.sv
// Module: sdt_cmd_decode
// Turns the raw strobe pins into a command and classifies it as addressed
// to one bank or to the whole device. Purely combinational.
// Assumes: a deselected cycle (cs_n high) is a no-op.
module sdt_cmd_decode
    import sdt_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd,
    output logic bank_cmd,
    output logic dev_cmd
);

    // Map the strobe pattern to a command; deselect forces a no-op.
    always_comb begin
        if (cs_n) begin
            cmd = C_NOP;
        end else begin
            cmd = cmd_e'({ras_n, cas_n, we_n});
        end
    end

    // Split commands into per-bank and device-wide groups.
    always_comb begin
        dev_cmd  = (cmd == C_REF) || (cmd == C_MRS);
        bank_cmd = !dev_cmd && (cmd != C_NOP);
    end

endmodule

// File: rtl/sdt_bank_fsm.sv
// Module: sdt_bank_fsm
// Condition tracker for one bank. It runs the burst and closing countdown
// and judges every per-bank command that addresses it (hit high). A rejected
// command is treated as a no-op, so the countdown keeps running.
// Assumes: device-wide commands never reach this module as hits.
module sdt_bank_fsm
    import sdt_pkg::*;
#(
    parameter int BURST_LEN  = 4,
    parameter int PRE_CYCLES = 2,
    parameter int ROW_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             hit,
    input  logic             ap_bit,
    input  logic [ROW_W-1:0] row_addr,
    output bank_st_e         state,
    output logic [ROW_W-1:0] open_row,
    output logic             cmd_bad,
    output logic             is_idle
);

    localparam int CNT_MAX = (BURST_LEN > PRE_CYCLES) ? BURST_LEN : PRE_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX) + 1;
    localparam logic [CNT_W-1:0] BURST_LOAD = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] CLOSE_LOAD = CNT_W'(PRE_CYCLES - 1);

    bank_st_e         st_q, st_tick, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_tick, cnt_d;
    logic [ROW_W-1:0] row_q, row_d;
    logic             bad;

    // Advance on its own: burst countdown, then the closing countdown.
    always_comb begin
        st_tick  = st_q;
        cnt_tick = cnt_q;
        unique case (st_q)
            BK_RD, BK_WR: begin
                if (cnt_q == '0) st_tick = BK_OPEN;
                else             cnt_tick = cnt_q - CNT_W'(1);
            end
            BK_RD_AP, BK_WR_AP: begin
                if (cnt_q == '0) begin
                    st_tick  = BK_CLOSE;
                    cnt_tick = CLOSE_LOAD;
                end else begin
                    cnt_tick = cnt_q - CNT_W'(1);
                end
            end
            BK_CLOSE: begin
                if (cnt_q == '0) st_tick = BK_IDLE;
                else             cnt_tick = cnt_q - CNT_W'(1);
            end
            default: ;
        endcase
    end

    // Judge an addressed command and pick the next condition.
    always_comb begin
        st_d  = st_tick;
        cnt_d = cnt_tick;
        row_d = row_q;
        bad   = 1'b0;
        if (hit) begin
            unique case (cmd)
                C_ACT: begin
                    if (st_q == BK_IDLE) begin
                        st_d  = BK_OPEN;
                        row_d = row_addr;
                    end else begin
                        bad = 1'b1;
                    end
                end
                C_PRE: begin
                    if (st_q == BK_OPEN || st_q == BK_RD || st_q == BK_WR) st_d = BK_IDLE;
                    else if (st_q != BK_IDLE)                              bad  = 1'b1;
                end
                C_RD, C_WR: begin
                    if (st_q == BK_OPEN || st_q == BK_RD || st_q == BK_WR) begin
                        cnt_d = BURST_LOAD;
                        if (cmd == C_RD) st_d = ap_bit ? BK_RD_AP : BK_RD;
                        else             st_d = ap_bit ? BK_WR_AP : BK_WR;
                    end else begin
                        bad = 1'b1;
                    end
                end
                C_BST: begin
                    if (st_q == BK_RD) st_d = BK_OPEN;
                    else               bad  = 1'b1;
                end
                default: ;
            endcase
            if (bad) begin
                st_d  = st_tick;
                cnt_d = cnt_tick;
                row_d = row_q;
            end
        end
    end

    // Condition, counter and row registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
            row_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            row_q <= row_d;
        end
    end

    assign state    = st_q;
    assign open_row = row_q;
    assign cmd_bad  = bad;
    assign is_idle  = (st_q == BK_IDLE);

endmodule

// File: rtl/sdt_bank_tracker.sv
// Module: sdt_bank_tracker (top)
// Watches the command pins and keeps one condition tracker per bank. It
// routes per-bank commands by bank_sel, judges device-wide commands against
// all banks, and registers a one-cycle flag for any command not permitted.
// Assumes: BURST_LEN is 1, 2, 4 or 8; PRE_CYCLES is at least 1.
module sdt_bank_tracker
    import sdt_pkg::*;
#(
    parameter int BANKS      = 2,
    parameter int BURST_LEN  = 4,
    parameter int PRE_CYCLES = 2,
    parameter int ROW_W      = 12,
    localparam int BA_W      = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n,
    input  logic                   ras_n,
    input  logic                   cas_n,
    input  logic                   we_n,
    input  logic [BA_W-1:0]        bank_sel,
    input  logic                   ap_bit,
    input  logic [ROW_W-1:0]       row_addr,
    output logic [BANKS*3-1:0]     bank_state_o,
    output logic [BANKS*ROW_W-1:0] open_row_o,
    output logic                   illegal_o
);

    cmd_e             cmd;
    logic             bank_cmd;
    logic             dev_cmd;
    logic [BANKS-1:0] hit;
    logic [BANKS-1:0] bad;
    logic [BANKS-1:0] idle;
    logic             flag_d;
    logic             flag_q;

    sdt_cmd_decode u_dec (
        .cs_n    (cs_n),
        .ras_n   (ras_n),
        .cas_n   (cas_n),
        .we_n    (we_n),
        .cmd     (cmd),
        .bank_cmd(bank_cmd),
        .dev_cmd (dev_cmd)
    );

    // One tracker per bank; hit routes per-bank commands.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        bank_st_e st;

        assign hit[b] = bank_cmd && (bank_sel == BA_W'(b));

        sdt_bank_fsm #(
            .BURST_LEN (BURST_LEN),
            .PRE_CYCLES(PRE_CYCLES),
            .ROW_W     (ROW_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd),
            .hit     (hit[b]),
            .ap_bit  (ap_bit),
            .row_addr(row_addr),
            .state   (st),
            .open_row(open_row_o[b*ROW_W +: ROW_W]),
            .cmd_bad (bad[b]),
            .is_idle (idle[b])
        );

        assign bank_state_o[b*3 +: 3] = st;
    end

    // Device-wide commands need every bank idle; others use the bank verdict.
    always_comb begin
        if (dev_cmd) flag_d = !(&idle);
        else         flag_d = |bad;
    end

    // Register the flag so it lasts exactly one cycle per command.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign illegal_o = flag_q;

endmodule

// File: rtl/sdt_bank_tracker_chk.sv
// Module: sdt_bank_tracker_chk
// Protocol properties of the tracker, seen from its ports for bank 0.
// Attached to every sdt_bank_tracker instance by the bind below.
module sdt_bank_tracker_chk #(
    parameter int BANKS = 2,
    localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n,
    input logic               ras_n,
    input logic               cas_n,
    input logic               we_n,
    input logic [BA_W-1:0]    bank_sel,
    input logic [BANKS*3-1:0] bank_state_o,
    input logic               illegal_o
);

    logic [2:0] st0;
    logic [2:0] pins;
    logic       to0;

    assign st0  = bank_state_o[2:0];
    assign pins = {ras_n, cas_n, we_n};
    assign to0  = !cs_n && (bank_sel == '0);

    // R3: open row on an idle bank is accepted and opens it.
    p_open_from_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (to0 && pins == 3'b011 && st0 == 3'd0) |=> (st0 == 3'd1 && !illegal_o));

    // R7: close on an open bank returns it to idle.
    p_close_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (to0 && pins == 3'b010 && st0 == 3'd1) |=> (st0 == 3'd0 && !illegal_o));

    // R8: a second open row is flagged and leaves the bank open.
    p_reopen_flagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (to0 && pins == 3'b011 && st0 == 3'd1) |=> (illegal_o && st0 == 3'd1));

    // R5: read or write during an auto-close burst is flagged.
    p_autoclose_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (to0 && (pins == 3'b101 || pins == 3'b100) && (st0 == 3'd4 || st0 == 3'd5)) |=> illegal_o);

    // R9: device-wide command while bank 0 is busy is flagged.
    p_devwide_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && (pins == 3'b001 || pins == 3'b000) && st0 != 3'd0) |=> illegal_o);

    // R2: a deselected cycle never raises the flag.
    p_deselect_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !illegal_o);

    // R4: the unused condition code never appears.
    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st0 != 3'd7);

endmodule

bind sdt_bank_tracker sdt_bank_tracker_chk #(.BANKS(BANKS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .we_n        (we_n),
    .bank_sel    (bank_sel),
    .bank_state_o(bank_state_o),
    .illegal_o   (illegal_o)
);

// File: tb/sdt_bank_tracker_bench.sv
// Bench for sdt_bank_tracker: directed sequences, then weighted random
// commands, all compared against a reference model of the requirements.
module sdt_bank_tracker_bench;

    localparam int BL  = 4;
    localparam int PC  = 2;
    localparam int RW  = 12;

    localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                           K_ACT = 3'b011, K_WR = 3'b100, K_RD = 3'b101,
                           K_BST = 3'b110, K_NOP = 3'b111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic          bank_sel = 1'b0;
    logic          ap_bit = 1'b0;
    logic [RW-1:0] row_addr = '0;
    logic [5:0]    bank_state_o;
    logic [2*RW-1:0] open_row_o;
    logic          illegal_o;

    int checks = 0;
    int fails  = 0;

    // Model of both banks.
    int            mst [2];
    int            mcnt[2];
    logic [RW-1:0] mrow[2];
    bit            mill;

    always #10 clk = ~clk;

    sdt_bank_tracker #(.BANKS(2), .BURST_LEN(BL), .PRE_CYCLES(PC), .ROW_W(RW)) u_sdt_bank_tracker (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank_sel(bank_sel), .ap_bit(ap_bit), .row_addr(row_addr),
        .bank_state_o(bank_state_o), .open_row_o(open_row_o), .illegal_o(illegal_o)
    );

    // Expected next values of the model for one sampled command.
    task automatic model_cmd(input logic cs, input logic [2:0] k, input logic ba,
                             input logic ap, input logic [RW-1:0] row);
        int nst[2];
        int ncnt[2];
        logic [RW-1:0] nrow[2];
        bit bad = 0;
        logic [2:0] c = cs ? K_NOP : k;
        for (int b = 0; b < 2; b++) begin
            nst[b] = mst[b]; ncnt[b] = mcnt[b]; nrow[b] = mrow[b];
            case (mst[b])
                2, 3: if (mcnt[b] == 0) nst[b] = 1; else ncnt[b] = mcnt[b] - 1;
                4, 5: if (mcnt[b] == 0) begin nst[b] = 6; ncnt[b] = PC - 1; end
                      else ncnt[b] = mcnt[b] - 1;
                6:    if (mcnt[b] == 0) nst[b] = 0; else ncnt[b] = mcnt[b] - 1;
                default: ;
            endcase
        end
        if (c == K_REF || c == K_MRS) begin
            bad = (mst[0] != 0) || (mst[1] != 0);
        end else if (c != K_NOP) begin
            int b = int'(ba);
            int s = mst[b];
            bit opn = (s == 1 || s == 2 || s == 3);
            case (c)
                K_ACT: if (s == 0) begin nst[b] = 1; nrow[b] = row; end else bad = 1;
                K_PRE: if (opn) nst[b] = 0; else if (s != 0) bad = 1;
                K_RD, K_WR: if (opn) begin
                        nst[b]  = (c == K_RD) ? (ap ? 4 : 2) : (ap ? 5 : 3);
                        ncnt[b] = BL - 1;
                    end else bad = 1;
                K_BST: if (s == 2) nst[b] = 1; else bad = 1;
                default: ;
            endcase
            if (bad) begin
                // Rejected command: keep only the self-timed progress.
            end
        end
        for (int b = 0; b < 2; b++) begin
            mst[b] = nst[b]; mcnt[b] = ncnt[b]; mrow[b] = nrow[b];
        end
        mill = bad;
    endtask

    task automatic check(input string tag);
        logic [5:0]      es = {mst[1][2:0], mst[0][2:0]};
        logic [2*RW-1:0] er = {mrow[1], mrow[0]};
        checks++;
        if (bank_state_o !== es || open_row_o !== er || illegal_o !== mill) begin
            fails++;
            $display("FAIL %s: state=%h row=%h ill=%b expected state=%h row=%h ill=%b",
                     tag, bank_state_o, open_row_o, illegal_o, es, er, mill);
        end
    endtask

    // Drive one command after a falling edge, then check at the next one.
    task automatic cyc(input logic cs, input logic [2:0] k, input logic ba,
                       input logic ap, input logic [RW-1:0] row, input string tag);
        cs_n = cs; {ras_n, cas_n, we_n} = k; bank_sel = ba; ap_bit = ap; row_addr = row;
        model_cmd(cs, k, ba, ap, row);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic nops(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, K_NOP, 1'b0, 1'b0, '0, tag);
    endtask

    // Legal-leaning random command for a random bank.
    task automatic rand_cyc();
        logic       ba  = 1'($urandom);
        logic [2:0] k   = 3'($urandom);
        int         s   = mst[ba];
        int         pick = $urandom % 10;
        if (pick < 6) begin
            case (s)
                0: k = ($urandom % 4 == 0) ? K_REF : K_ACT;
                1, 2, 3: k = ($urandom % 5 == 0) ? K_PRE : (($urandom % 2) ? K_RD : K_WR);
                default: k = K_NOP;
            endcase
            if (s == 2 && $urandom % 4 == 0) k = K_BST;
        end
        cyc(($urandom % 8) == 0, k, ba, ($urandom % 3) == 0, RW'($urandom), "R8 model");
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int b = 0; b < 2; b++) begin mst[b] = 0; mcnt[b] = 0; mrow[b] = '0; end
        mill = 0;
        repeat (3) @(negedge clk);
        check("R1 reset");
        rst_n = 1'b1;

        // R1 still idle after release; R2 deselect with odd pins.
        cyc(1'b1, K_ACT, 1'b0, 1'b0, 12'h111, "R2 deselect");
        cyc(1'b0, K_ACT, 1'b0, 1'b0, 12'h123, "R3 open bank0");
        cyc(1'b0, K_ACT, 1'b1, 1'b0, 12'h456, "R10 open bank1");
        cyc(1'b0, K_RD,  1'b0, 1'b0, '0,      "R4 read start");
        nops(BL, "R4 read length");
        cyc(1'b0, K_WR,  1'b1, 1'b0, '0,      "R4 write start");
        cyc(1'b0, K_BST, 1'b1, 1'b0, '0,      "R8 stop in write");
        cyc(1'b1, K_BST, 1'b1, 1'b0, '0,      "R2 burst continues");
        nops(BL, "R4 write length");
        cyc(1'b0, K_RD,  1'b0, 1'b0, '0,      "R6 read again");
        cyc(1'b0, K_BST, 1'b0, 1'b0, '0,      "R6 stop in read");
        cyc(1'b0, K_RD,  1'b0, 1'b0, '0,      "R6 read");
        cyc(1'b0, K_NOP, 1'b0, 1'b0, '0,      "R6 nop");
        cyc(1'b0, K_WR,  1'b0, 1'b0, '0,      "R6 cut by write");
        nops(BL + 1, "R6 full new burst");
        cyc(1'b0, K_ACT, 1'b1, 1'b0, 12'hABC, "R8 reopen open bank");
        cyc(1'b0, K_REF, 1'b0, 1'b0, '0,      "R9 refresh busy");
        cyc(1'b0, K_WR,  1'b0, 1'b1, '0,      "R4 write auto-close");
        cyc(1'b0, K_RD,  1'b0, 1'b0, '0,      "R8 read in auto-close");
        cyc(1'b0, K_PRE, 1'b0, 1'b0, '0,      "R8 close in auto-close");
        nops(BL + PC + 1, "R5 close countdown");
        cyc(1'b0, K_PRE, 1'b0, 1'b0, '0,      "R7 close idle");
        cyc(1'b0, K_RD,  1'b0, 1'b0, '0,      "R8 read idle");
        cyc(1'b0, K_PRE, 1'b1, 1'b0, '0,      "R7 close bank1");
        cyc(1'b0, K_REF, 1'b1, 1'b0, '0,      "R9 refresh idle");
        cyc(1'b0, K_MRS, 1'b0, 1'b0, '0,      "R9 mode write idle");
        cyc(1'b0, K_ACT, 1'b1, 1'b0, 12'h0F0, "R3 open bank1");
        cyc(1'b0, K_RD,  1'b1, 1'b1, '0,      "R4 read auto-close");
        cyc(1'b0, K_ACT, 1'b0, 1'b0, 12'h777, "R10 other bank opens");
        cyc(1'b0, K_MRS, 1'b0, 1'b0, '0,      "R9 mode write busy");
        nops(BL + PC, "R5 read close");
        cyc(1'b0, K_PRE, 1'b0, 1'b0, '0,      "R7 close bank0");

        for (int i = 0; i < 4000; i++) rand_cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule